// File: doc/BRIEF.md
# Mantissa Rounding Stage

This block is the rounding step of a floating-point datapath. It receives an unpacked mantissa whose two lowest bits hold the guard bit and the round bit. It also receives a separate sticky bit, the sign of the operand, and a two-bit rounding-direction select. From these it decides whether the kept part of the mantissa must be bumped by one unit in the last place. It drops the guard and round bits, applies the increment with a carry that runs through the whole kept field, and reports whether it rounded up and whether any precision was lost.

The stage does not renormalise. When every kept bit is one and the stage rounds up, the carry lands in one extra top bit of the result, which then reads as 2.0. The packer downstream is expected to detect and fix that case. The stage does no exponent work and no packing. A parameter chooses between a purely combinational path and one output register stage.

Top module: `rnd_unit`

## Requirements
- R1: Bit 1 of `mant_in` is the guard bit and bit 0 is the round bit. When no increment is applied, `mant_out` equals `mant_in` shifted right by two, zero-extended into the top bit.
- R2: `sticky_out` is always 0.
- R3: When guard, round and sticky are all 0, `round_up` is 0, `inexact` is 0 and `mant_out` is the shifted input, in every mode.
- R4: When any of guard, round or sticky is 1, `inexact` is 1, in every mode.
- R5: With `mode_in` = 2'b00 (nearest), the stage rounds up only if the guard bit is 1 and at least one of the round bit, the sticky bit or the lowest kept bit is 1. This gives ties-to-even.
- R6: With `mode_in` = 2'b01 (toward zero), the stage never rounds up.
- R7: With `mode_in` = 2'b10 (toward minus infinity), the stage rounds up only when the result is inexact and `sign_in` is 1. With `mode_in` = 2'b11 (toward plus infinity), it rounds up only when the result is inexact and `sign_in` is 0.
- R8: When rounding up, `mant_out` equals the shifted input plus one. The carry runs across the full kept width. An all-ones kept field becomes a 1 in the top bit of `mant_out` with all lower bits 0.
- R9: `round_up` is 1 exactly when the increment is applied to `mant_out`.
- R10: With REG_OUT = 0, all outputs follow the inputs in the same cycle. With REG_OUT = 1, they appear one rising edge of `clk` later, and an active-low `rst_n` clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset for the output register |
| mant_in | input | MANT_W | Unpacked mantissa; bit 1 is the guard bit, bit 0 is the round bit |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Operand sign, 1 = negative |
| mode_in | input | 2 | Rounding direction: 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| mant_out | output | MANT_W-1 | Rounded kept mantissa; the top bit catches the carry out |
| sticky_out | output | 1 | Sticky after rounding, always 0 |
| round_up | output | 1 | The kept field was incremented |
| inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
A narrow instance is swept over every mantissa value, both sticky values, both signs and all four directions. This covers every guard/round/sticky combination against both parities of the lowest kept bit. It separates a true tie that holds at an even value from ties that move to odd, and it separates the directed modes by sign. In the same sweep, the all-ones kept field shows whether the carry reaches the top bit. A registered instance is swept to show the one-edge latency and the cleared reset state, and a full-width instance takes directed carry and tie cases.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TO_ZERO = 2'b01,
    RM_TO_NEG  = 2'b10,
    RM_TO_POS  = 2'b11
  } rmode_e;

  // Any discarded bit set means the kept value differs from the true one.
  function automatic logic rp_lost(input logic g, input logic r, input logic s);
    return g | r | s;
  endfunction

  // Decide on an increment of one unit in the last kept place.
  function automatic logic rp_want_up(input rmode_e m, input logic neg,
                                      input logic g, input logic r,
                                      input logic s, input logic lsb);
    logic lost;
    logic up;
    lost = rp_lost(g, r, s);
    case (m)
      RM_NEAREST: up = g & (r | s | lsb);
      RM_TO_ZERO: up = 1'b0;
      RM_TO_NEG:  up = lost & neg;
      RM_TO_POS:  up = lost & ~neg;
      default:    up = 1'b0;
    endcase
    return up;
  endfunction

endpackage

// File: rtl/rnd_split.sv
module rnd_split #(
  parameter int MANT_W = 66
) (
  input  logic [MANT_W-1:0] mant_in,
  output logic [MANT_W-3:0] kept,
  output logic              guard,
  output logic              rbit,
  output logic              lsb
);
  localparam int KEEP_W = MANT_W - 2;

  assign kept  = mant_in[MANT_W-1:2];
  assign guard = mant_in[1];
  assign rbit  = mant_in[0];
  assign lsb   = kept[0];

  initial begin
    if (KEEP_W < 1) $error("rnd_split: MANT_W must be at least 3");
  end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       neg,
  input  logic       guard,
  input  logic       rbit,
  input  logic       sticky,
  input  logic       lsb,
  output logic       up,
  output logic       lost
);
  rmode_e mode_e;

  always_comb begin
    mode_e = rmode_e'(mode);
    lost   = rp_lost(guard, rbit, sticky);
    up     = rp_want_up(mode_e, neg, guard, rbit, sticky, lsb);
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int KEEP_W = 64
) (
  input  logic [KEEP_W-1:0] a,
  input  logic              inc,
  output logic [KEEP_W:0]   sum,
  output logic              carry_out
);
  logic [KEEP_W:0] carry;

  assign carry[0] = inc;

  for (genvar i = 0; i < KEEP_W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ carry[i];
    assign carry[i+1] = a[i] & carry[i];
  end

  assign sum[KEEP_W] = carry[KEEP_W];
  assign carry_out   = carry[KEEP_W];
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit #(
  parameter int MANT_W  = 66,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic [MANT_W-2:0] mant_out,
  output logic              sticky_out,
  output logic              round_up,
  output logic              inexact
);
  localparam int KEEP_W = MANT_W - 2;
  localparam int OUT_W  = MANT_W - 1;

  // Named internal events, used by the bound checker.
  logic [KEEP_W-1:0] kept_w;
  logic              guard_w;
  logic              rbit_w;
  logic              lsb_w;
  logic              up_w;
  logic              inexact_w;
  logic [OUT_W-1:0]  sum_w;
  logic              carry_w;

  rnd_split #(.MANT_W(MANT_W)) u_split (
    .mant_in (mant_in),
    .kept    (kept_w),
    .guard   (guard_w),
    .rbit    (rbit_w),
    .lsb     (lsb_w)
  );

  rnd_decide u_dec (
    .mode    (mode_in),
    .neg     (sign_in),
    .guard   (guard_w),
    .rbit    (rbit_w),
    .sticky  (sticky_in),
    .lsb     (lsb_w),
    .up      (up_w),
    .lost    (inexact_w)
  );

  rnd_incr #(.KEEP_W(KEEP_W)) u_inc (
    .a         (kept_w),
    .inc       (up_w),
    .sum       (sum_w),
    .carry_out (carry_w)
  );

  assign sticky_out = 1'b0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mant_out <= '0;
        round_up <= 1'b0;
        inexact  <= 1'b0;
      end else begin
        mant_out <= sum_w;
        round_up <= up_w;
        inexact  <= inexact_w;
      end
    end
  end else begin : g_comb
    assign mant_out = sum_w;
    assign round_up = up_w;
    assign inexact  = inexact_w;
  end
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int MANT_W  = 66,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MANT_W-1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic [MANT_W-3:0] kept_w,
  input logic              up_w,
  input logic              inexact_w,
  input logic [MANT_W-2:0] sum_w,
  input logic              carry_w,
  input logic [MANT_W-2:0] mant_out,
  input logic              round_up,
  input logic              inexact
);
  assert_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mant_in[1:0] == 2'b00 && !sticky_in) |-> (!up_w && !inexact_w));

  assert_inexact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mant_in[1:0] != 2'b00 || sticky_in) |-> inexact_w);

  assert_near_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b00 && !mant_in[1]) |-> !up_w);

  assert_zero_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b01) |-> !up_w);

  assert_neg_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b10 && !sign_in) |-> !up_w);

  assert_pos_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 2'b11 && sign_in) |-> !up_w);

  assert_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sum_w == ({1'b0, kept_w} + {{(MANT_W-2){1'b0}}, up_w}));

  assert_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_w |-> (up_w && (&kept_w)));

  if (REG_OUT) begin : g_lat
    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (round_up == $past(up_w) && mant_out == $past(sum_w)
                 && inexact == $past(inexact_w)));
  end else begin : g_nolat
    assert_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      round_up == up_w && mant_out == sum_w);
  end
endmodule

bind rnd_unit rnd_unit_chk #(.MANT_W(MANT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mant_in   (mant_in),
  .sticky_in (sticky_in),
  .sign_in   (sign_in),
  .mode_in   (mode_in),
  .kept_w    (kept_w),
  .up_w      (up_w),
  .inexact_w (inexact_w),
  .sum_w     (sum_w),
  .carry_w   (carry_w),
  .mant_out  (mant_out),
  .round_up  (round_up),
  .inexact   (inexact)
);

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W0 = 6;
  localparam int W1 = 8;
  localparam int W2 = 66;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_checks = 0;
  int   n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0: narrow, combinational
  logic [W0-1:0] m0 = '0;
  logic s0 = 0, g0 = 0;
  logic [1:0] md0 = 2'b00;
  logic [W0-2:0] o0;
  logic st0, up0, ix0;

  rnd_unit #(.MANT_W(W0), .REG_OUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .mant_in(m0), .sticky_in(s0), .sign_in(g0),
    .mode_in(md0), .mant_out(o0), .sticky_out(st0), .round_up(up0), .inexact(ix0));

  // u1: registered
  logic [W1-1:0] m1 = '0;
  logic s1 = 0, g1 = 0;
  logic [1:0] md1 = 2'b00;
  logic [W1-2:0] o1;
  logic st1, up1, ix1;

  rnd_unit #(.MANT_W(W1), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .mant_in(m1), .sticky_in(s1), .sign_in(g1),
    .mode_in(md1), .mant_out(o1), .sticky_out(st1), .round_up(up1), .inexact(ix1));

  // u2: full width, combinational
  logic [W2-1:0] m2 = '0;
  logic s2 = 0, g2 = 0;
  logic [1:0] md2 = 2'b00;
  logic [W2-2:0] o2;
  logic st2, up2, ix2;

  rnd_unit #(.MANT_W(W2), .REG_OUT(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .mant_in(m2), .sticky_in(s2), .sign_in(g2),
    .mode_in(md2), .mant_out(o2), .sticky_out(st2), .round_up(up2), .inexact(ix2));

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected rounding by value comparison: the discarded part is frac/8 of an ulp.
  function automatic bit ref_up(input int md, input int sg, input int frac, input int kept);
    case (md)
      0: return (frac > 4) || (frac == 4 && (kept % 2) == 1);
      1: return 1'b0;
      2: return (frac != 0) && (sg == 1);
      default: return (frac != 0) && (sg == 0);
    endcase
  endfunction

  function automatic string mode_tag(input int md);
    case (md)
      0: return "R5";
      1: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state of the registered instance (R10)
    repeat (2) @(negedge clk);
    chk("R10", "reset mant_out", longint'(o1), 0);
    chk("R10", "reset round_up", longint'(up1), 0);
    chk("R10", "reset inexact", longint'(ix1), 0);
    chk("R2", "reset sticky_out", longint'(st1), 0);
    rst_n = 1'b1;

    // Exhaustive sweep on the narrow combinational instance
    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int st = 0; st < 2; st++) begin
          for (int mv = 0; mv < (1 << W0); mv++) begin
            int kept, frac, exp_out;
            bit eu;
            @(negedge clk);
            m0 = mv[W0-1:0]; s0 = st[0]; g0 = sg[0]; md0 = md[1:0];
            #1;
            kept = mv >> 2;
            frac = (mv % 4) * 2 + st;
            eu = ref_up(md, sg, frac, kept);
            exp_out = kept + int'(eu);
            if (!eu) chk("R1", "shifted mant_out", longint'(o0), exp_out);
            else if (kept == (1 << (W0-2)) - 1) chk("R8", "carry mant_out", longint'(o0), exp_out);
            else chk(mode_tag(md), "rounded mant_out", longint'(o0), exp_out);
            chk("R9", "round_up flag", longint'(up0), longint'(eu));
            if (frac == 0) chk("R3", "exact inexact", longint'(ix0), 0);
            else chk("R4", "inexact flag", longint'(ix0), 1);
            chk("R2", "sticky_out", longint'(st0), 0);
          end
        end
      end
    end

    // Registered instance: one-edge latency
    for (int mv = 0; mv < (1 << W1); mv++) begin
      int kept, frac, md, sg, st;
      bit eu;
      longint prev_o;
      md = mv % 4; sg = (mv / 4) % 2; st = (mv / 8) % 2;
      @(negedge clk);
      prev_o = longint'(o1);
      m1 = mv[W1-1:0]; s1 = st[0]; g1 = sg[0]; md1 = md[1:0];
      #1;
      chk("R10", "held before edge", longint'(o1), prev_o);
      @(negedge clk);
      kept = mv >> 2;
      frac = (mv % 4) * 2 + st;
      eu = ref_up(md, sg, frac, kept);
      chk("R10", "registered mant_out", longint'(o1), kept + int'(eu));
      chk("R10", "registered round_up", longint'(up1), longint'(eu));
      chk("R10", "registered inexact", longint'(ix1), longint'(frac != 0));
    end

    // Full width directed cases
    @(negedge clk);
    m2 = '1; s2 = 0; g2 = 0; md2 = 2'b00;
    #1;
    n_checks++;
    if (o2 !== {1'b1, {(W2-2){1'b0}}}) begin
      n_errors++;
      $display("FAIL R8 full carry: actual %h expected %h", o2, {1'b1, {(W2-2){1'b0}}});
    end
    chk("R9", "full carry round_up", longint'(up2), 1);

    @(negedge clk);
    m2 = {{(W2-4){1'b0}}, 4'b1010}; s2 = 0; g2 = 0; md2 = 2'b00;  // kept=2, tie
    #1;
    chk("R5", "tie stays even", longint'(o2[31:0]), 2);
    chk("R5", "tie no round", longint'(up2), 0);

    @(negedge clk);
    m2 = {{(W2-4){1'b0}}, 4'b0110}; s2 = 0; g2 = 1; md2 = 2'b00;  // kept=1, tie
    #1;
    chk("R5", "tie to even up", longint'(o2[31:0]), 2);

    @(negedge clk);
    m2 = {{(W2-4){1'b0}}, 4'b0101}; s2 = 1; g2 = 1; md2 = 2'b11;
    #1;
    chk("R7", "plus-inf negative", longint'(up2), 0);
    chk("R4", "plus-inf inexact", longint'(ix2), 1);

    finish_run();
  end
endmodule